// File: doc/BRIEF.md
# Programmable status hold-off filter

This block sits between raw status detectors and the rest of a disc servo controller. It cleans up two status flags: a frame-sync-good flag and a focus-OK flag. Each flag goes high in the same cycle its raw condition is true. When the raw condition goes false, the flag stays high until the condition has stayed false for a programmable time, and then it drops. Each flag has its own table of four choices. Code 0 means no hold. Codes 1 to 3 select hold lengths of increasing size.

Hold lengths are counted in ticks from a free-running prescaler. Each tick lasts `TICK_DIV` clock cycles. The tick count is divided by a speed setting of 1x, 2x or 4x, so the hold time shrinks as playback speeds up.

Configuration arrives as 16-bit command words from a microcontroller port. A word with bit 15 clear is a coefficient write. The block does not store it: it passes the write on as a one-cycle strobe with the address and data. A word with bit 15 set and bits 14..12 clear is a mode write. It loads the two hold codes and the mirror time-constant bits, which are exported to a neighbouring block.

Top module: `status_hold_filter`

## Requirements
- R1: A valid word with bit 15 = 0 makes `coef_we_o` high in the next cycle, with `coef_addr_o` = bits 14..8 and `coef_data_o` = bits 7..0 of that word.
- R2: A valid word with bit 15 = 1 and bits 14..12 = 000 is a mode write, effective from the next cycle:
  - the frame-sync hold code is loaded from bits 11..10;
  - the focus-OK hold code is loaded from bits 9..8;
  - `mirr_slow_o` is loaded from bit 4 (0 = normal time constant, 1 = slower);
  - `mirr_set_o` is loaded from bits 3..2;
  - bits 7..5 and 1..0 have no effect.
- R3: After reset the following hold:
  - both hold codes, `mirr_slow_o` and `mirr_set_o` are 0;
  - `coef_we_o` is 0;
  - each flag output equals its raw input.
- R4: A valid word with bit 15 = 1 and bits 14..12 not all zero is ignored. It raises no strobe and changes no mode field.
- R5: While a raw input is 1, its flag output is 1 in the same cycle.
- R6: With hold code 00, a flag output follows its raw input in the same cycle, in both directions.
- R7: At 1x speed, the frame-sync flag falls after it has been continuously false for the following number of ticks, depending on its hold code:
  - code 01: `FS_T1` ticks (default 4);
  - code 10: `FS_T2` ticks (default 8);
  - code 11: `FS_T3` ticks (default 16).
- R8: At 1x speed, the focus-OK flag falls after it has been continuously false for the following number of ticks, depending on its hold code:
  - code 01: `FOK_T1` ticks (default 9);
  - code 10: `FOK_T2` ticks (default 20);
  - code 11: `FOK_T3` ticks (default 44).
- R9: The 2-bit speed input scales the hold length as follows, with a floor of one tick:
  - 00 (1x): the table value is used;
  - 01 (2x): the table value is halved;
  - 10 or 11 (4x): the table value is quartered.
- R10: Any return of a raw input to 1 during a hold restarts that flag's hold interval from zero.
- R11: `coef_we_o` is high for exactly one cycle per coefficient write and is never high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command word valid for one cycle |
| cmd_word_i | input | 16 | Command word |
| speed_i | input | 2 | Speed: 00 = 1x, 01 = 2x, 1x = 4x |
| fs_raw_i | input | 1 | Raw frame-sync-correct condition |
| fok_raw_i | input | 1 | Raw focus-above-slice condition |
| fs_good_o | output | 1 | Filtered frame-sync-good flag |
| fok_good_o | output | 1 | Filtered focus-OK flag |
| coef_we_o | output | 1 | Coefficient write strobe |
| coef_addr_o | output | 7 | Coefficient address |
| coef_data_o | output | 8 | Coefficient data |
| mirr_slow_o | output | 1 | Mirror time-constant select |
| mirr_set_o | output | 2 | Mirror setting field |

## Verification
The assertions check on every cycle the parts of the block that fit a one- or two-cycle window:
- command decoding, that is, the strobe contents, mode loading and ignored words;
- that the strobe only ever follows a coefficient write;
- that a raw 1 forces the flag high at once;
- that hold code 00 makes the flag a pure follower.

Only the bench scenarios can show the hold lengths themselves. These are the per-flag tick tables, the division by speed, and the restart of the interval when the raw condition briefly returns. The bench measures each hold against a one-tick window that allows for the prescaler's free-running phase.

// File: rtl/shf_pkg.sv
package shf_pkg;

  typedef struct packed {
    logic [1:0] fs_code;
    logic [1:0] fok_code;
    logic       mirr_slow;
    logic [1:0] mirr_set;
  } mode_t;

  localparam mode_t MODE_RST = '0;

  function automatic int unsigned hold_base(logic [1:0] code, int unsigned t1,
                                            int unsigned t2, int unsigned t3);
    case (code)
      2'b01:   return t1;
      2'b10:   return t2;
      2'b11:   return t3;
      default: return 0;
    endcase
  endfunction

  // 00: 1x, 01: 2x, 1x: 4x; never below one tick
  function automatic int unsigned scale_hold(int unsigned base, logic [1:0] spd);
    int unsigned r;
    if (spd[1])      r = base >> 2;
    else if (spd[0]) r = base >> 1;
    else             r = base;
    return (r == 0) ? 1 : r;
  endfunction

endpackage

// File: rtl/shf_cmd_decode.sv
module shf_cmd_decode
  import shf_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [WORD_W-1:0] cmd_word_i,
  output logic              coef_we_o,
  output logic [ADDR_W-1:0] coef_addr_o,
  output logic [DATA_W-1:0] coef_data_o,
  output mode_t             mode_o
);

  logic is_coef, is_mode;

  assign is_coef = cmd_valid_i && !cmd_word_i[15];
  assign is_mode = cmd_valid_i && cmd_word_i[15] && (cmd_word_i[14:12] == 3'b000);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coef_we_o   <= 1'b0;
      coef_addr_o <= '0;
      coef_data_o <= '0;
    end else begin
      coef_we_o <= is_coef;
      if (is_coef) begin
        coef_addr_o <= cmd_word_i[DATA_W +: ADDR_W];
        coef_data_o <= cmd_word_i[DATA_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= MODE_RST;
    end else if (is_mode) begin
      mode_o.fs_code   <= cmd_word_i[11:10];
      mode_o.fok_code  <= cmd_word_i[9:8];
      mode_o.mirr_slow <= cmd_word_i[4];
      mode_o.mirr_set  <= cmd_word_i[3:2];
    end
  end

endmodule

// File: rtl/shf_tick_gen.sv
module shf_tick_gen #(
  parameter int unsigned TICK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);

  localparam int unsigned TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [TW-1:0] LAST = TW'(TICK_DIV - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

endmodule

// File: rtl/shf_hold_filter.sv
module shf_hold_filter #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          raw_i,
  input  logic          enable_i,
  input  logic [CW-1:0] limit_i,
  output logic          flag_o
);

  logic          hold_q;
  logic [CW-1:0] cnt_q;
  logic [CW:0]   cnt_nx;

  assign cnt_nx = {1'b0, cnt_q} + {{CW{1'b0}}, 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      cnt_q  <= '0;
    end else if (raw_i) begin
      hold_q <= enable_i;
      cnt_q  <= '0;
    end else if (!enable_i) begin
      hold_q <= 1'b0;
      cnt_q  <= '0;
    end else if (hold_q && tick_i) begin
      if (cnt_nx >= {1'b0, limit_i}) begin
        hold_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_nx[CW-1:0];
      end
    end
  end

  // enable gating keeps code 00 a pure follower even mid-hold
  assign flag_o = raw_i | (hold_q & enable_i);

endmodule

// File: rtl/status_hold_filter.sv
module status_hold_filter
  import shf_pkg::*;
#(
  parameter int unsigned TICK_DIV = 4,
  parameter int unsigned CW       = 8,
  parameter int unsigned FS_T1    = 4,
  parameter int unsigned FS_T2    = 8,
  parameter int unsigned FS_T3    = 16,
  parameter int unsigned FOK_T1   = 9,
  parameter int unsigned FOK_T2   = 20,
  parameter int unsigned FOK_T3   = 44
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_valid_i,
  input  logic [15:0] cmd_word_i,
  input  logic [1:0]  speed_i,
  input  logic        fs_raw_i,
  input  logic        fok_raw_i,
  output logic        fs_good_o,
  output logic        fok_good_o,
  output logic        coef_we_o,
  output logic [6:0]  coef_addr_o,
  output logic [7:0]  coef_data_o,
  output logic        mirr_slow_o,
  output logic [1:0]  mirr_set_o
);

  localparam int unsigned NFLAG = 2;

  mode_t         mode_q;
  logic          tick;
  logic [NFLAG-1:0] raw_vec, en_vec, flag_vec;
  logic [CW-1:0] lim_vec [NFLAG];

  shf_cmd_decode #(.WORD_W(16), .ADDR_W(7), .DATA_W(8)) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_valid_i),
    .cmd_word_i (cmd_word_i),
    .coef_we_o  (coef_we_o),
    .coef_addr_o(coef_addr_o),
    .coef_data_o(coef_data_o),
    .mode_o     (mode_q)
  );

  shf_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  assign raw_vec = {fok_raw_i, fs_raw_i};
  assign en_vec  = {mode_q.fok_code != 2'b00, mode_q.fs_code != 2'b00};

  always_comb begin
    lim_vec[0] = CW'(scale_hold(hold_base(mode_q.fs_code, FS_T1, FS_T2, FS_T3), speed_i));
    lim_vec[1] = CW'(scale_hold(hold_base(mode_q.fok_code, FOK_T1, FOK_T2, FOK_T3), speed_i));
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flt
    shf_hold_filter #(.CW(CW)) u_flt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick),
      .raw_i   (raw_vec[g]),
      .enable_i(en_vec[g]),
      .limit_i (lim_vec[g]),
      .flag_o  (flag_vec[g])
    );
  end

  assign fs_good_o   = flag_vec[0];
  assign fok_good_o  = flag_vec[1];
  assign mirr_slow_o = mode_q.mirr_slow;
  assign mirr_set_o  = mode_q.mirr_set;

endmodule

// File: rtl/shf_checker.sv
module shf_checker
  import shf_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cmd_valid_i,
  input logic [15:0] cmd_word_i,
  input logic        fs_raw_i,
  input logic        fok_raw_i,
  input logic        fs_good_o,
  input logic        fok_good_o,
  input logic        coef_we_o,
  input logic [6:0]  coef_addr_o,
  input logic [7:0]  coef_data_o,
  input logic        mirr_slow_o,
  input logic [1:0]  mirr_set_o,
  input mode_t       mode_q
);

  a_r1_coef_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !cmd_word_i[15]) |=>
      (coef_we_o && coef_addr_o == $past(cmd_word_i[14:8]) && coef_data_o == $past(cmd_word_i[7:0])));

  a_r2_mode_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_word_i[15] && cmd_word_i[14:12] == 3'b000) |=>
      (mirr_slow_o == $past(cmd_word_i[4]) && mirr_set_o == $past(cmd_word_i[3:2]) &&
       mode_q.fs_code == $past(cmd_word_i[11:10]) && mode_q.fok_code == $past(cmd_word_i[9:8])));

  a_r4_ignored_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_word_i[15] && cmd_word_i[14:12] != 3'b000) |=>
      (!coef_we_o && $stable(mode_q)));

  a_r11_strobe_origin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coef_we_o |-> $past(cmd_valid_i && !cmd_word_i[15]));

  a_r5_fs_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_raw_i |-> fs_good_o);

  a_r5_fok_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fok_raw_i |-> fok_good_o);

  a_r6_fs_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q.fs_code == 2'b00) |-> (fs_good_o == fs_raw_i));

  a_r6_fok_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q.fok_code == 2'b00) |-> (fok_good_o == fok_raw_i));

endmodule

bind status_hold_filter shf_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_valid_i(cmd_valid_i),
  .cmd_word_i (cmd_word_i),
  .fs_raw_i   (fs_raw_i),
  .fok_raw_i  (fok_raw_i),
  .fs_good_o  (fs_good_o),
  .fok_good_o (fok_good_o),
  .coef_we_o  (coef_we_o),
  .coef_addr_o(coef_addr_o),
  .coef_data_o(coef_data_o),
  .mirr_slow_o(mirr_slow_o),
  .mirr_set_o (mirr_set_o),
  .mode_q     (mode_q)
);

// File: tb/status_hold_filter_bench.sv
`timescale 1ns/1ps
module status_hold_filter_bench;

  localparam int D = 4;  // ticks are D cycles

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_word = '0;
  logic [1:0]  speed = 2'b00;
  logic        fs_raw = 1'b0, fok_raw = 1'b0;
  logic        fs_good, fok_good, coef_we, mirr_slow;
  logic [6:0]  coef_addr;
  logic [7:0]  coef_data;
  logic [1:0]  mirr_set;

  int total = 0, bad = 0;

  always #5 clk = ~clk;

  status_hold_filter #(.TICK_DIV(D)) u_status_hold_filter (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_word_i(cmd_word),
    .speed_i(speed), .fs_raw_i(fs_raw), .fok_raw_i(fok_raw),
    .fs_good_o(fs_good), .fok_good_o(fok_good), .coef_we_o(coef_we),
    .coef_addr_o(coef_addr), .coef_data_o(coef_data),
    .mirr_slow_o(mirr_slow), .mirr_set_o(mirr_set)
  );

  typedef struct packed {
    logic [15:0] cmd;
    logic        we;
    logic [6:0]  addr;
    logic [7:0]  data;
    logic        slow;
    logic [1:0]  set;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{16'h0000, 1'b1, 7'h00, 8'h00, 1'b0, 2'd0},
    '{16'h7FA5, 1'b1, 7'h7F, 8'hA5, 1'b0, 2'd0},
    '{16'h1234, 1'b1, 7'h12, 8'h34, 1'b0, 2'd0},
    '{16'h8F1C, 1'b0, 7'h00, 8'h00, 1'b1, 2'd3},
    '{16'h9000, 1'b0, 7'h00, 8'h00, 1'b1, 2'd3},
    '{16'hF0EC, 1'b0, 7'h00, 8'h00, 1'b1, 2'd3},
    '{16'h8008, 1'b0, 7'h00, 8'h00, 1'b0, 2'd2},
    '{16'h80E3, 1'b0, 7'h00, 8'h00, 1'b0, 2'd0},
    '{16'h5A00, 1'b1, 7'h5A, 8'h00, 1'b0, 2'd0}
  };

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(logic [15:0] w);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = w;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_word  = '0;
  endtask

  task automatic set_codes(logic [1:0] fs_c, logic [1:0] fok_c);
    send({4'h8, fs_c, fok_c, 8'h00});
  endtask

  task automatic set_raw(bit sel, logic v);
    if (sel) fok_raw = v; else fs_raw = v;
  endtask

  function automatic logic flag(bit sel);
    return sel ? fok_good : fs_good;
  endfunction

  // after the falling edge of raw: high after (lim-1)*D edges, low by lim*D edges
  task automatic hold_window(bit sel, int lim, string tag);
    @(negedge clk);
    set_raw(sel, 1'b1);
    repeat (3) @(negedge clk);
    set_raw(sel, 1'b0);
    #1 chk({tag, " held right after fall"}, flag(sel), 1);
    repeat ((lim - 1) * D) @(negedge clk);
    #1 chk({tag, " still held"}, flag(sel), 1);
    repeat (D) @(negedge clk);
    #1 chk({tag, " released"}, flag(sel), 0);
  endtask

  initial begin
    #2_000_000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R3 we at reset", coef_we, 0);
    chk("R3 mirr_slow at reset", mirr_slow, 0);
    chk("R3 mirr_set at reset", mirr_set, 0);
    rst_n = 1'b1;
    @(negedge clk);
    fs_raw = 1'b1;
    fok_raw = 1'b1;
    #1 chk("R3 fs follows raw high", fs_good, 1);
    chk("R5 fok immediate rise", fok_good, 1);
    @(negedge clk);
    fs_raw = 1'b0;
    fok_raw = 1'b0;
    #1 chk("R3 fs follows raw low", fs_good, 0);
    chk("R6 fok bypass low", fok_good, 0);

    // command vector walk
    for (int i = 0; i < NV; i++) begin
      send(VECS[i].cmd);
      #1;
      chk($sformatf("R1 we vec%0d", i), coef_we, VECS[i].we);
      if (VECS[i].we) begin
        chk($sformatf("R1 addr vec%0d", i), coef_addr, VECS[i].addr);
        chk($sformatf("R1 data vec%0d", i), coef_data, VECS[i].data);
      end
      chk($sformatf("R2 R4 mirr_slow vec%0d", i), mirr_slow, VECS[i].slow);
      chk($sformatf("R2 R4 mirr_set vec%0d", i), mirr_set, VECS[i].set);
      @(negedge clk);
      #1 chk($sformatf("R11 strobe dropped vec%0d", i), coef_we, 0);
    end

    // hold tables at 1x
    speed = 2'b00;
    set_codes(2'b01, 2'b00);
    hold_window(1'b0, 4, "R7 fs code01");
    set_codes(2'b10, 2'b00);
    hold_window(1'b0, 8, "R7 fs code10");
    set_codes(2'b11, 2'b01);
    hold_window(1'b0, 16, "R7 fs code11");
    hold_window(1'b1, 9, "R8 fok code01");
    set_codes(2'b00, 2'b10);
    hold_window(1'b1, 20, "R8 fok code10");
    set_codes(2'b00, 2'b11);
    hold_window(1'b1, 44, "R8 fok code11");

    // bypass with a hold code elsewhere
    @(negedge clk);
    fs_raw = 1'b1;
    @(negedge clk);
    fs_raw = 1'b0;
    #1 chk("R6 fs code00 drops at once", fs_good, 0);

    // speed scaling
    speed = 2'b01;
    set_codes(2'b11, 2'b11);
    hold_window(1'b0, 8, "R9 fs code11 2x");
    speed = 2'b10;
    hold_window(1'b1, 11, "R9 fok code11 4x");
    speed = 2'b11;
    set_codes(2'b01, 2'b10);
    hold_window(1'b1, 5, "R9 fok code10 speed11");
    hold_window(1'b0, 1, "R9 fs code01 4x floor");

    // ignored command must not alter the hold code
    speed = 2'b00;
    set_codes(2'b10, 2'b00);
    send(16'hB000);
    #1 chk("R4 no strobe on ignored", coef_we, 0);
    hold_window(1'b0, 8, "R4 fs code kept");

    // retrigger restarts the interval
    @(negedge clk);
    fs_raw = 1'b1;
    repeat (2) @(negedge clk);
    fs_raw = 1'b0;
    repeat (5 * D) @(negedge clk);
    #1 chk("R10 held before retrigger", fs_good, 1);
    fs_raw = 1'b1;
    @(negedge clk);
    fs_raw = 1'b0;
    repeat (7 * D) @(negedge clk);
    #1 chk("R10 held after restart", fs_good, 1);
    repeat (D) @(negedge clk);
    #1 chk("R10 released after restart", fs_good, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule